// File: doc/BRIEF.md
# Accelerator Performance Counter Unit

This block sits next to a matrix-multiply accelerator and keeps a set of running totals. Host software uses these totals to place a workload on a roofline plot. It watches the array's busy flag, a per-cycle count of active multiply-accumulate units, and the read and write handshakes of the memory interface with their byte sizes. From these it keeps six saturating counters:

- elapsed cycles,
- array busy cycles,
- read transactions,
- write transactions,
- bytes moved,
- arithmetic operations.

Host software divides operations by bytes to get arithmetic intensity, and divides busy cycles by elapsed cycles to get utilisation.

A synchronous clear zeroes every counter. An enable input freezes them all. A word-addressed read port with one cycle of latency exposes each counter as a low word and a high word. Reading the low word captures the matching high word into a snapshot register, so a wide value is read consistently while it keeps changing.

Top module: `perf_counter_unit`

## Requirements
- R1: After reset every counter is zero and `reg_rdata` is zero.
- R2: Counter 0 (cycles) adds one on every clock edge at which `cnt_en` is high.
- R3: Counter 1 (busy) adds one on every enabled edge at which `arr_busy` is high.
- R4: Counter 2 counts enabled edges with `rd_fire` high, and counter 3 counts enabled edges with `wr_fire` high. The two counters are independent.
- R5: Counter 4 (bytes) adds `rd_bytes` when `rd_fire` is high plus `wr_bytes` when `wr_fire` is high, on each enabled edge.
- R6: Counter 5 (operations) adds twice `mac_active` on each enabled edge. A `mac_active` value above NUM_PE counts as NUM_PE.
- R7: While `cnt_en` is low, no counter changes.
- R8: `clr` high zeroes all six counters at the next edge. It takes priority over `cnt_en` and over all increments.
- R9: A counter whose next sum would pass its maximum value (all ones in CNT_W bits) stops at that maximum and does not wrap.
- R10: When `reg_rd_en` is high at an edge, `reg_rdata` shows the read one cycle later, using the counter value from before that edge.
  - Word address 2k returns the low RD_W bits of counter k, and word address 2k+1 returns the high part.
  - Addresses 12 and above return zero.
  - `reg_rdata` holds its value in cycles without a read.
- R11: A read of an even address copies the high part of that counter into one shared snapshot register. A read of any odd address returns this snapshot, not the live high part.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of all counters |
| cnt_en | input | 1 | Counting enable; low freezes all counters |
| arr_busy | input | 1 | Array is computing this cycle |
| mac_active | input | MAC_W | Number of active MAC units this cycle |
| rd_fire | input | 1 | A memory read transaction completes this cycle |
| rd_bytes | input | BYTE_W | Bytes carried by that read |
| wr_fire | input | 1 | A memory write transaction completes this cycle |
| wr_bytes | input | BYTE_W | Bytes carried by that write |
| reg_rd_en | input | 1 | Register read request |
| reg_addr | input | AW | Word address of the read |
| reg_rdata | output | RD_W | Read data, valid one cycle after the request |

## Verification
The hardest states to reach from the ports are saturation and a high word that changes between the two halves of a read. With 64-bit counters, neither can happen in a run of any practical length. The bench therefore adds a second instance with a 12-bit counter and an 8-bit read word, driven by the same stimulus. On that instance the operations counter crosses its low-word boundary within a few cycles and saturates within a few hundred. This lets directed sequences read the low word, keep counting, and then show that the high read returns the snapshot and that counters stop at all ones. Constrained random traffic, including out-of-range `mac_active` values and random reads, is checked against a bench model of every counter.

// File: rtl/perf_pkg.sv
package perf_pkg;
   localparam int unsigned NUM_CNT = 6;

   typedef enum logic [2:0] {
      CNT_CYCLES = 3'd0,
      CNT_BUSY   = 3'd1,
      CNT_RD_TXN = 3'd2,
      CNT_WR_TXN = 3'd3,
      CNT_BYTES  = 3'd4,
      CNT_OPS    = 3'd5
   } cnt_id_e;
endpackage

// File: rtl/perf_sat_acc.sv
module perf_sat_acc #(
   parameter int unsigned W     = 64,
   parameter int unsigned INC_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             en,
   input  logic [INC_W-1:0] inc,
   output logic [W-1:0]     q
);
   generate
      if (INC_W > W) begin : g_bad_width
         $error("perf_sat_acc: increment wider than counter");
      end
   endgenerate

   logic [W:0] sum;

   always_comb begin
      sum = {1'b0, q} + {{(W + 1 - INC_W){1'b0}}, inc};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= '0;
      end else if (clr) begin
         q <= '0;
      end else if (en) begin
         q <= sum[W] ? {W{1'b1}} : sum[W-1:0];
      end
   end
endmodule

// File: rtl/perf_inc_gen.sv
module perf_inc_gen
   import perf_pkg::*;
#(
   parameter int unsigned NUM_PE = 16,
   parameter int unsigned MAC_W  = 5,
   parameter int unsigned BYTE_W = 8,
   parameter int unsigned INC_W  = 9
) (
   input  logic                              arr_busy,
   input  logic [MAC_W-1:0]                  mac_active,
   input  logic                              rd_fire,
   input  logic [BYTE_W-1:0]                 rd_bytes,
   input  logic                              wr_fire,
   input  logic [BYTE_W-1:0]                 wr_bytes,
   output logic [NUM_CNT-1:0][INC_W-1:0]     inc
);
   localparam logic [MAC_W-1:0] PE_MAX = MAC_W'(NUM_PE);

   logic [MAC_W-1:0]  mac_lim;
   logic [BYTE_W:0]   byte_sum;

   always_comb begin
      mac_lim  = (mac_active > PE_MAX) ? PE_MAX : mac_active;
      byte_sum = (rd_fire ? {1'b0, rd_bytes} : '0)
               + (wr_fire ? {1'b0, wr_bytes} : '0);
      inc             = '0;
      inc[CNT_CYCLES] = INC_W'(1);
      inc[CNT_BUSY]   = INC_W'(arr_busy);
      inc[CNT_RD_TXN] = INC_W'(rd_fire);
      inc[CNT_WR_TXN] = INC_W'(wr_fire);
      inc[CNT_BYTES]  = INC_W'(byte_sum);
      inc[CNT_OPS]    = INC_W'({mac_lim, 1'b0});
   end
endmodule

// File: rtl/perf_readout.sv
module perf_readout #(
   parameter int unsigned NCNT  = 6,
   parameter int unsigned CNT_W = 64,
   parameter int unsigned RD_W  = 32,
   parameter int unsigned AW    = 4
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [NCNT-1:0][CNT_W-1:0]  cnt,
   input  logic                        rd_en,
   input  logic [AW-1:0]               addr,
   output logic [RD_W-1:0]             rdata
);
   logic [NCNT-1:0][2*RD_W-1:0] wide;
   logic [RD_W-1:0]             lo_sel, hi_sel, snap;
   logic                        in_map;
   logic [AW-2:0]               idx;

   generate
      if (CNT_W == 2 * RD_W) begin : g_full
         assign wide = cnt;
      end else begin : g_pad
         always_comb begin
            for (int k = 0; k < NCNT; k++) begin
               wide[k]            = '0;
               wide[k][CNT_W-1:0] = cnt[k];
            end
         end
      end
   endgenerate

   always_comb begin
      idx    = addr[AW-1:1];
      in_map = 1'b0;
      lo_sel = '0;
      hi_sel = '0;
      for (int k = 0; k < NCNT; k++) begin
         if (idx == (AW-1)'(k)) begin
            in_map = 1'b1;
            lo_sel = wide[k][RD_W-1:0];
            hi_sel = wide[k][2*RD_W-1:RD_W];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata <= '0;
         snap  <= '0;
      end else if (rd_en) begin
         if (!in_map) begin
            rdata <= '0;
         end else if (addr[0]) begin
            rdata <= snap;
         end else begin
            rdata <= lo_sel;
            snap  <= hi_sel;
         end
      end
   end
endmodule

// File: rtl/perf_counter_unit.sv
module perf_counter_unit
   import perf_pkg::*;
#(
   parameter int unsigned NUM_PE = 16,
   parameter int unsigned BYTE_W = 8,
   parameter int unsigned CNT_W  = 64,
   parameter int unsigned RD_W   = 32,
   localparam int unsigned MAC_W = $clog2(NUM_PE + 1),
   localparam int unsigned AW    = $clog2(2 * NUM_CNT)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              cnt_en,
   input  logic              arr_busy,
   input  logic [MAC_W-1:0]  mac_active,
   input  logic              rd_fire,
   input  logic [BYTE_W-1:0] rd_bytes,
   input  logic              wr_fire,
   input  logic [BYTE_W-1:0] wr_bytes,
   input  logic              reg_rd_en,
   input  logic [AW-1:0]     reg_addr,
   output logic [RD_W-1:0]   reg_rdata
);
   localparam int unsigned INC_W = ((BYTE_W + 1) > (MAC_W + 1)) ? (BYTE_W + 1) : (MAC_W + 1);

   generate
      if (NUM_PE < 1) begin : g_bad_pe
         $error("perf_counter_unit: NUM_PE must be at least 1");
      end
      if (CNT_W > 2 * RD_W || CNT_W <= RD_W) begin : g_bad_rd
         $error("perf_counter_unit: CNT_W must lie in (RD_W, 2*RD_W]");
      end
      if (INC_W > CNT_W) begin : g_bad_cnt
         $error("perf_counter_unit: CNT_W too narrow for increments");
      end
   endgenerate

   logic [NUM_CNT-1:0][INC_W-1:0] inc;
   logic [NUM_CNT-1:0][CNT_W-1:0] cnt_q;

   perf_inc_gen #(
      .NUM_PE (NUM_PE),
      .MAC_W  (MAC_W),
      .BYTE_W (BYTE_W),
      .INC_W  (INC_W)
   ) u_inc (
      .arr_busy   (arr_busy),
      .mac_active (mac_active),
      .rd_fire    (rd_fire),
      .rd_bytes   (rd_bytes),
      .wr_fire    (wr_fire),
      .wr_bytes   (wr_bytes),
      .inc        (inc)
   );

   generate
      for (genvar k = 0; k < NUM_CNT; k++) begin : g_cnt
         perf_sat_acc #(
            .W     (CNT_W),
            .INC_W (INC_W)
         ) u_acc (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (clr),
            .en    (cnt_en),
            .inc   (inc[k]),
            .q     (cnt_q[k])
         );
      end
   endgenerate

   perf_readout #(
      .NCNT  (NUM_CNT),
      .CNT_W (CNT_W),
      .RD_W  (RD_W),
      .AW    (AW)
   ) u_rd (
      .clk   (clk),
      .rst_n (rst_n),
      .cnt   (cnt_q),
      .rd_en (reg_rd_en),
      .addr  (reg_addr),
      .rdata (reg_rdata)
   );
endmodule

// File: rtl/perf_mon_chk.sv
module perf_mon_chk #(
   parameter int unsigned NCNT  = 6,
   parameter int unsigned CNT_W = 64,
   parameter int unsigned RD_W  = 32
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    clr,
   input logic                    cnt_en,
   input logic                    arr_busy,
   input logic                    rd_fire,
   input logic                    reg_rd_en,
   input logic [RD_W-1:0]         reg_rdata,
   input logic [NCNT*CNT_W-1:0]   cnt_flat
);
   logic [CNT_W-1:0] c_cyc, c_busy, c_rd;
   assign c_cyc  = cnt_flat[0*CNT_W +: CNT_W];
   assign c_busy = cnt_flat[1*CNT_W +: CNT_W];
   assign c_rd   = cnt_flat[2*CNT_W +: CNT_W];

   // R8
   clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt_flat == '0));

   // R7
   freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cnt_en && !clr) |=> $stable(cnt_flat));

   // R2
   cycle_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_en && !clr && (c_cyc != {CNT_W{1'b1}})) |=> (c_cyc == $past(c_cyc) + CNT_W'(1)));

   // R3
   busy_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!arr_busy && !clr) |=> $stable(c_busy));

   // R4
   rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_fire && !clr) |=> $stable(c_rd));

   // R10
   rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_rd_en |=> $stable(reg_rdata));

   generate
      for (genvar k = 0; k < NCNT; k++) begin : g_mono
         // R9
         no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !clr |=> (cnt_flat[k*CNT_W +: CNT_W] >= $past(cnt_flat[k*CNT_W +: CNT_W])));
      end
   endgenerate
endmodule

bind perf_counter_unit perf_mon_chk #(
   .NCNT  (perf_pkg::NUM_CNT),
   .CNT_W (CNT_W),
   .RD_W  (RD_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .clr       (clr),
   .cnt_en    (cnt_en),
   .arr_busy  (arr_busy),
   .rd_fire   (rd_fire),
   .reg_rd_en (reg_rd_en),
   .reg_rdata (reg_rdata),
   .cnt_flat  (cnt_q)
);

// File: tb/sim_perf_counter_unit.sv
`timescale 1ns/1ps
module sim_perf_counter_unit;
   localparam int NPE = 16;
   localparam int RDW0 = 32, CW0 = 64;
   localparam int RDW1 = 8,  CW1 = 12;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic clr = 0, cnt_en = 0, arr_busy = 0, rd_fire = 0, wr_fire = 0, reg_rd_en = 0;
   logic [4:0] mac_active = '0;
   logic [7:0] rd_bytes = '0, wr_bytes = '0;
   logic [3:0] reg_addr = '0;
   logic [RDW0-1:0] rdata0;
   logic [RDW1-1:0] rdata1;

   int checks = 0;
   int fails  = 0;

   logic [63:0] m    [2][6];
   logic [63:0] snap [2];
   logic [63:0] ex   [2];

   always #2 clk = ~clk;

   perf_counter_unit #(.NUM_PE(NPE), .BYTE_W(8), .CNT_W(CW0), .RD_W(RDW0)) u0 (
      .clk(clk), .rst_n(rst_n), .clr(clr), .cnt_en(cnt_en), .arr_busy(arr_busy),
      .mac_active(mac_active), .rd_fire(rd_fire), .rd_bytes(rd_bytes),
      .wr_fire(wr_fire), .wr_bytes(wr_bytes), .reg_rd_en(reg_rd_en),
      .reg_addr(reg_addr), .reg_rdata(rdata0));

   perf_counter_unit #(.NUM_PE(NPE), .BYTE_W(8), .CNT_W(CW1), .RD_W(RDW1)) u1 (
      .clk(clk), .rst_n(rst_n), .clr(clr), .cnt_en(cnt_en), .arr_busy(arr_busy),
      .mac_active(mac_active), .rd_fire(rd_fire), .rd_bytes(rd_bytes),
      .wr_fire(wr_fire), .wr_bytes(wr_bytes), .reg_rd_en(reg_rd_en),
      .reg_addr(reg_addr), .reg_rdata(rdata1));

   function automatic logic [63:0] sat_add(logic [63:0] v, logic [63:0] inc, int w);
      logic [64:0] s, lim;
      s   = {1'b0, v} + {1'b0, inc};
      lim = (w >= 64) ? {1'b0, {64{1'b1}}} : ((65'd1 << w) - 65'd1);
      return (s > lim) ? lim[63:0] : s[63:0];
   endfunction

   function automatic logic [63:0] mask_of(int w);
      return (w >= 64) ? {64{1'b1}} : ((64'd1 << w) - 64'd1);
   endfunction

   task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // one clock: inputs already driven, model advances at the edge, returns at negedge
   task automatic tick();
      logic [63:0] inc [6];
      int mac;
      @(posedge clk);
      mac = (mac_active > NPE) ? NPE : int'(mac_active);
      inc[0] = 1;
      inc[1] = arr_busy;
      inc[2] = rd_fire;
      inc[3] = wr_fire;
      inc[4] = (rd_fire ? 64'(rd_bytes) : 0) + (wr_fire ? 64'(wr_bytes) : 0);
      inc[5] = 64'(2 * mac);
      for (int j = 0; j < 2; j++) begin
         int w, rw;
         w  = (j == 0) ? CW0 : CW1;
         rw = (j == 0) ? RDW0 : RDW1;
         if (rst_n && reg_rd_en) begin
            if (reg_addr >= 12) ex[j] = 0;
            else if (reg_addr[0]) ex[j] = snap[j];
            else begin
               ex[j]   = m[j][reg_addr[3:1]] & mask_of(rw);
               snap[j] = (m[j][reg_addr[3:1]] >> rw) & mask_of(rw);
            end
         end
         for (int k = 0; k < 6; k++) begin
            if (clr) m[j][k] = 0;
            else if (cnt_en) m[j][k] = sat_add(m[j][k], inc[k], w);
         end
      end
      @(negedge clk);
   endtask

   task automatic idle_in();
      clr = 0; arr_busy = 0; mac_active = 0; rd_fire = 0; wr_fire = 0;
      rd_bytes = 0; wr_bytes = 0; reg_rd_en = 0;
   endtask

   task automatic chk_rd(string tag);
      chk({tag, " u0"}, 64'(rdata0), ex[0]);
      chk({tag, " u1"}, 64'(rdata1), ex[1]);
   endtask

   task automatic rd_counter(int k, string tag);
      reg_rd_en = 1; reg_addr = 4'(2 * k);
      tick();
      chk_rd({tag, " low"});
      reg_addr = 4'(2 * k + 1);
      tick();
      chk_rd({tag, " high"});
      reg_rd_en = 0;
   endtask

   task automatic rd_all(string pfx);
      rd_counter(0, {pfx, " R2 cycles"});
      rd_counter(1, {pfx, " R3 busy"});
      rd_counter(2, {pfx, " R4 reads"});
      rd_counter(3, {pfx, " R4 writes"});
      rd_counter(4, {pfx, " R5 bytes"});
      rd_counter(5, {pfx, " R6 ops"});
   endtask

   task automatic rand_in();
      arr_busy   = 1'($urandom);
      mac_active = 5'($urandom);
      rd_fire    = 1'($urandom);
      wr_fire    = 1'($urandom);
      rd_bytes   = 8'($urandom);
      wr_bytes   = 8'($urandom);
   endtask

   initial begin
      #(4.0 * 200000);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      void'($urandom(32'd4242));
      for (int j = 0; j < 2; j++) begin
         snap[j] = 0; ex[j] = 0;
         for (int k = 0; k < 6; k++) m[j][k] = 0;
      end
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 rdata u0", 64'(rdata0), 0);
      chk("R1 rdata u1", 64'(rdata1), 0);
      rst_n = 1;
      rd_all("R1");

      // random traffic with interleaved reads
      cnt_en = 1;
      for (int i = 0; i < 300; i++) begin
         rand_in();
         reg_rd_en = ($urandom % 4) == 0;
         reg_addr  = 4'($urandom);
         tick();
         if (reg_rd_en) chk_rd("R10 random read");
      end
      idle_in();
      cnt_en = 0;
      rd_all("random");

      // R7 freeze with activity present
      for (int i = 0; i < 40; i++) begin rand_in(); tick(); end
      idle_in();
      rd_all("R7 frozen");

      // R10 unmapped addresses and hold
      for (int a = 12; a < 16; a++) begin
         reg_rd_en = 1; reg_addr = 4'(a); tick(); chk_rd("R10 unmapped");
      end
      reg_rd_en = 1; reg_addr = 4'd8; tick();
      reg_rd_en = 0; reg_addr = 4'd0;
      repeat (3) tick();
      chk_rd("R10 hold");

      // R8 clear while enabled and active
      cnt_en = 1; rand_in(); clr = 1; tick(); clr = 0;
      idle_in(); cnt_en = 0;
      rd_all("R8 cleared");

      // R6 clamp: three cycles with an out-of-range value
      cnt_en = 1; mac_active = 5'd31; repeat (3) tick();
      cnt_en = 0; idle_in();
      reg_rd_en = 1; reg_addr = 4'd10; tick();
      chk("R6 clamp u0", 64'(rdata0), 96);
      chk("R6 clamp u1", 64'(rdata1), 96);
      reg_rd_en = 0;

      // R11 snapshot on narrow instance
      clr = 1; tick(); clr = 0;
      cnt_en = 1; mac_active = 5'd16;
      repeat (10) tick();
      reg_rd_en = 1; reg_addr = 4'd10; tick();
      chk("R11 low u1", 64'(rdata1), 64);
      reg_rd_en = 0;
      repeat (10) tick();
      reg_rd_en = 1; reg_addr = 4'd11; tick();
      chk("R11 snapshot u1", 64'(rdata1), 1);
      reg_addr = 4'd1; tick();
      chk("R11 shared u1", 64'(rdata1), 1);
      reg_rd_en = 0;

      // R9 saturation on narrow instance
      repeat (150) tick();
      cnt_en = 0; idle_in();
      reg_rd_en = 1; reg_addr = 4'd10; tick();
      chk("R9 sat low u1", 64'(rdata1), 255);
      reg_addr = 4'd11; tick();
      chk("R9 sat high u1", 64'(rdata1), 15);
      reg_rd_en = 0;
      rd_all("R9 final");

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule